// File: doc/BRIEF.md
# Time Base and Watchdog Timer

This block turns a 32 kHz system clock into a programmable periodic signal and a watchdog. A shared counter, made of a prescaler of 2^PRE_LOG2 system clocks followed by seven further binary stages, drives both functions. A 3-bit rate code picks one bit of this counter. That bit is the time-base square wave, at 2^code Hz when PRE_LOG2 is 8 (code 0 gives 1 Hz, code 7 gives 128 Hz). Each time the selected bit falls, the counter produces a tick. The watchdog counts these ticks and sets a sticky time-out flag on the fourth one.

A single active-low interrupt line reports either the watchdog flag or the time-base wave. It is modelled as open drain: `irq_drive_o` is the pull-down enable, and `irq_level_o` is the level seen on a line with a pull-up. Decoded one-cycle command strobes control the block. Separate strobes turn the time base, the watchdog and the interrupt on or off, clear the shared counter, clear the watchdog stage, and load the rate code. A host must clear the watchdog periodically so that the flag does not pull the line low.

Top module: `tbase_wdog`

## Requirements
- R1: After reset the time base, the watchdog and the interrupt are all off, the rate code is 7, the shared counter and the watchdog stage are zero, and the line is released (`irq_drive_o`=0, `irq_level_o`=1).
- R2: The shared counter advances by one on every clock while the time base or the watchdog is on. It holds its value while both are off.
- R3: The counter bit at position PRE_LOG2+6-code is the wave. When the interrupt and the time base are on and the flag is clear, the line is low while this bit is 0 and high while it is 1. The full period is 2^(PRE_LOG2+7-code) clocks, and the line starts low right after a counter clear.
- R4: A tick occurs on any counting clock whose counter bits from PRE_LOG2+6-code down to bit 0 are all ones. With the watchdog on, its 2-bit stage counts ticks and the flag sets on the fourth tick. From a clear of both the counter and the watchdog, this is 4*2^(PRE_LOG2+7-code) clocks.
- R5: Once the flag is set and the interrupt is on, the line is pulled low regardless of the wave. It stays low until a watchdog-clear or interrupt-off strobe. Either strobe clears the flag on the next edge.
- R6: The counter-clear strobe zeroes the shared counter and leaves the watchdog stage and flag untouched. The watchdog-clear strobe zeroes the watchdog stage and flag and leaves the counter untouched.
- R7: The on/off state of the time base, the watchdog and the interrupt are held separately. A strobe for one leaves the other two unchanged.
- R8: When the on and off strobes of one function arrive in the same clock, off wins. A counter-clear in the same clock as counting gives zero and produces no tick.
- R9: While the interrupt is off the line is released, whatever the flag and the wave. `irq_level_o` is always the inverse of `irq_drive_o`.
- R10: A rate load takes effect on the next edge without clearing the counter. The wave and the tick position follow the new code from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32 kHz system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| timer_on_i | input | 1 | Strobe: turn time base on |
| timer_off_i | input | 1 | Strobe: turn time base off |
| timer_clr_i | input | 1 | Strobe: zero the shared counter |
| wdog_on_i | input | 1 | Strobe: turn watchdog on |
| wdog_off_i | input | 1 | Strobe: turn watchdog off |
| wdog_clr_i | input | 1 | Strobe: zero watchdog stage and flag |
| irq_on_i | input | 1 | Strobe: enable the interrupt line |
| irq_off_i | input | 1 | Strobe: release the line and drop the flag |
| rate_load_i | input | 1 | Strobe: load rate_i as the rate code |
| rate_i | input | 3 | Rate code, 0 (slowest) to 7 (fastest) |
| irq_level_o | output | 1 | Resolved line level, active low |
| irq_drive_o | output | 1 | Pull-down enable of the open-drain line |

## Verification
The bench clears the counter and the watchdog together and checks the exact edge of the fourth tick. A design with the tick one counter bit off, or that counts three or five ticks, misses that edge. It strobes a counter clear while the flag holds the line low, and it issues a watchdog clear and an interrupt-off. A flag tied to the wrong clear, or one that fails to stick, shows up as an early release or a line stuck low. It changes rate codes in mid-period and pairs on/off strobes in one clock. A model that restarts the counter on a rate load, or lets "on" win, drifts from the cycle-accurate reference at once.

// File: rtl/tbw_pkg.sv
package tbw_pkg;

  localparam int unsigned RATE_W     = 3;
  localparam int unsigned DIV_STAGES = 7;

  typedef logic [RATE_W-1:0] rate_t;

  localparam rate_t RATE_AT_RESET = 3'd7;

  // index of the counter bit that forms the selected wave
  function automatic int unsigned wave_bit(input int unsigned pre_log2, input rate_t code);
    return pre_log2 + DIV_STAGES - 1 - 32'(code);
  endfunction

  // full period of the selected wave, in system clocks
  function automatic int unsigned wave_period(input int unsigned pre_log2, input rate_t code);
    return 32'd1 << (wave_bit(pre_log2, code) + 1);
  endfunction

endpackage

// File: rtl/tbw_ctrl.sv
module tbw_ctrl
  import tbw_pkg::*;
#(
  parameter int unsigned NUM_FN = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_FN-1:0] on_i,
  input  logic [NUM_FN-1:0] off_i,
  input  logic              rate_load_i,
  input  rate_t             rate_i,
  output logic [NUM_FN-1:0] en_o,
  output rate_t             rate_o
);

  for (genvar g = 0; g < NUM_FN; g++) begin : g_en
    logic en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       en_q <= 1'b0;
      else if (off_i[g]) en_q <= 1'b0;
      else if (on_i[g])  en_q <= 1'b1;
    end
    assign en_o[g] = en_q;
  end

  rate_t rate_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          rate_q <= RATE_AT_RESET;
    else if (rate_load_i) rate_q <= rate_i;
  end
  assign rate_o = rate_q;

endmodule

// File: rtl/tbw_chain.sv
module tbw_chain
  import tbw_pkg::*;
#(
  parameter int unsigned PRE_LOG2 = 8,
  localparam int unsigned CW      = PRE_LOG2 + DIV_STAGES,
  localparam int unsigned IDX_W   = $clog2(CW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          clr_i,
  input  rate_t         rate_i,
  output logic [CW-1:0] cnt_o,
  output logic          wave_o,
  output logic          tick_o
);

  localparam logic [CW-1:0] ONES = '1;

  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    low_mask;
  logic [IDX_W-1:0] sel_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_q + CW'(1);
  end

  always_comb begin
    sel_idx  = IDX_W'(wave_bit(PRE_LOG2, rate_i));
    low_mask = ONES >> (CW - 1 - wave_bit(PRE_LOG2, rate_i));
    wave_o   = cnt_q[sel_idx];
    tick_o   = run_i && !clr_i && ((cnt_q & low_mask) == low_mask);
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/tbw_watchdog.sv
module tbw_watchdog #(
  parameter int unsigned TICKS   = 4,
  localparam int unsigned STAGE_W = $clog2(TICKS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               tick_i,
  input  logic               clr_i,
  input  logic               drop_i,
  output logic [STAGE_W-1:0] stage_o,
  output logic               flag_o,
  output logic               timeout_o
);

  logic [STAGE_W-1:0] stage_q;
  logic               flag_q;

  assign timeout_o = en_i && tick_i && !clr_i && (stage_q == STAGE_W'(TICKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            stage_q <= '0;
    else if (clr_i)         stage_q <= '0;
    else if (timeout_o)     stage_q <= '0;
    else if (en_i && tick_i) stage_q <= stage_q + STAGE_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              flag_q <= 1'b0;
    else if (clr_i || drop_i) flag_q <= 1'b0;
    else if (timeout_o)       flag_q <= 1'b1;
  end

  assign stage_o = stage_q;
  assign flag_o  = flag_q;

endmodule

// File: rtl/tbase_wdog.sv
module tbase_wdog
  import tbw_pkg::*;
#(
  parameter int unsigned PRE_LOG2   = 8,
  parameter int unsigned WDOG_TICKS = 4,
  localparam int unsigned CNT_W     = PRE_LOG2 + DIV_STAGES,
  localparam int unsigned STAGE_W   = $clog2(WDOG_TICKS)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       timer_on_i,
  input  logic       timer_off_i,
  input  logic       timer_clr_i,
  input  logic       wdog_on_i,
  input  logic       wdog_off_i,
  input  logic       wdog_clr_i,
  input  logic       irq_on_i,
  input  logic       irq_off_i,
  input  logic       rate_load_i,
  input  logic [2:0] rate_i,
  output logic       irq_level_o,
  output logic       irq_drive_o
);

  localparam int unsigned FN_TIMER = 0;
  localparam int unsigned FN_WDOG  = 1;
  localparam int unsigned FN_IRQ   = 2;

  logic [2:0]         fn_en;
  rate_t              rate_q;
  logic               timer_en_q, wdog_en_q, irq_en_q;
  logic [CNT_W-1:0]   chain_cnt;
  logic               tb_wave, tb_tick;
  logic [STAGE_W-1:0] wdog_stage;
  logic               wdog_flag, wdog_timeout;
  logic               pull_low;

  tbw_ctrl #(.NUM_FN(3)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .on_i        ({irq_on_i,  wdog_on_i,  timer_on_i}),
    .off_i       ({irq_off_i, wdog_off_i, timer_off_i}),
    .rate_load_i (rate_load_i),
    .rate_i      (rate_t'(rate_i)),
    .en_o        (fn_en),
    .rate_o      (rate_q)
  );

  assign timer_en_q = fn_en[FN_TIMER];
  assign wdog_en_q  = fn_en[FN_WDOG];
  assign irq_en_q   = fn_en[FN_IRQ];

  tbw_chain #(.PRE_LOG2(PRE_LOG2)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (timer_en_q || wdog_en_q),
    .clr_i  (timer_clr_i),
    .rate_i (rate_q),
    .cnt_o  (chain_cnt),
    .wave_o (tb_wave),
    .tick_o (tb_tick)
  );

  tbw_watchdog #(.TICKS(WDOG_TICKS)) u_wdog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (wdog_en_q),
    .tick_i    (tb_tick),
    .clr_i     (wdog_clr_i),
    .drop_i    (irq_off_i),
    .stage_o   (wdog_stage),
    .flag_o    (wdog_flag),
    .timeout_o (wdog_timeout)
  );

  // open-drain line: the flag dominates, otherwise the wave drives when the time base runs
  assign pull_low    = irq_en_q && (wdog_flag || (timer_en_q && !tb_wave));
  assign irq_drive_o = pull_low;
  assign irq_level_o = !pull_low;

endmodule

// File: rtl/tbase_wdog_checker.sv
module tbase_wdog_checker #(
  parameter int unsigned CNT_W   = 15,
  parameter int unsigned STAGE_W = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               timer_on_i,
  input logic               timer_off_i,
  input logic               timer_clr_i,
  input logic               wdog_clr_i,
  input logic               irq_off_i,
  input logic               timer_en_q,
  input logic               wdog_en_q,
  input logic               irq_en_q,
  input logic [CNT_W-1:0]   chain_cnt,
  input logic               tb_tick,
  input logic [STAGE_W-1:0] wdog_stage,
  input logic               wdog_flag,
  input logic               irq_drive_o,
  input logic               irq_level_o
);

  a_r2_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!timer_en_q && !wdog_en_q && !timer_clr_i) |=> $stable(chain_cnt));

  a_r6_counter_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_clr_i |=> (chain_cnt == '0));

  a_r4_flag_on_last_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdog_flag) |-> $past(wdog_en_q && tb_tick && (wdog_stage == '1)));

  a_r5_flag_holds_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdog_flag && irq_en_q && !wdog_clr_i && !irq_off_i) |=> (irq_drive_o && wdog_flag));

  a_r5_flag_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdog_clr_i || irq_off_i) |=> !wdog_flag);

  a_r8_off_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timer_on_i && timer_off_i) |=> !timer_en_q);

  a_r9_released_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_q |-> (!irq_drive_o && irq_level_o));

endmodule

bind tbase_wdog tbase_wdog_checker #(.CNT_W(CNT_W), .STAGE_W(STAGE_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .timer_on_i  (timer_on_i),
  .timer_off_i (timer_off_i),
  .timer_clr_i (timer_clr_i),
  .wdog_clr_i  (wdog_clr_i),
  .irq_off_i   (irq_off_i),
  .timer_en_q  (timer_en_q),
  .wdog_en_q   (wdog_en_q),
  .irq_en_q    (irq_en_q),
  .chain_cnt   (chain_cnt),
  .tb_tick     (tb_tick),
  .wdog_stage  (wdog_stage),
  .wdog_flag   (wdog_flag),
  .irq_drive_o (irq_drive_o),
  .irq_level_o (irq_level_o)
);

// File: tb/tbase_wdog_tb_top.sv
`timescale 1ns/1ps
module tbase_wdog_tb_top;

  localparam int PW = 2;

  // strobe vector bit positions
  localparam int T_ON = 0, T_OFF = 1, T_CLR = 2, W_ON = 3, W_OFF = 4,
                 W_CLR = 5, I_ON = 6, I_OFF = 7, R_LD = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] cmd = '0;
  logic [2:0] rate = 3'd0;
  logic       irq_level, irq_drive;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  string phase = "R1";

  always #4 clk = ~clk;

  tbase_wdog #(.PRE_LOG2(PW)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .timer_on_i  (cmd[T_ON]),
    .timer_off_i (cmd[T_OFF]),
    .timer_clr_i (cmd[T_CLR]),
    .wdog_on_i   (cmd[W_ON]),
    .wdog_off_i  (cmd[W_OFF]),
    .wdog_clr_i  (cmd[W_CLR]),
    .irq_on_i    (cmd[I_ON]),
    .irq_off_i   (cmd[I_OFF]),
    .rate_load_i (cmd[R_LD]),
    .rate_i      (rate),
    .irq_level_o (irq_level),
    .irq_drive_o (irq_drive)
  );

  // behavioural reference model
  int m_cnt, m_stage, m_rate;
  bit m_t, m_w, m_i, m_flag;
  localparam int MOD = 1 << (PW + 7);

  function automatic int period_of(int code);
    return 1 << (PW + 7 - code);
  endfunction

  function automatic bit model_level();
    bit low_half;
    low_half = ((m_cnt / (period_of(m_rate) / 2)) % 2) == 0;
    return !(m_i && (m_flag || (m_t && low_half)));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_stage = 0; m_rate = 7;
      m_t = 0; m_w = 0; m_i = 0; m_flag = 0;
    end else begin
      bit run, tick, tout;
      run  = m_t || m_w;
      tick = run && !cmd[T_CLR] && (((m_cnt + 1) % period_of(m_rate)) == 0);
      tout = m_w && tick && (m_stage == 3) && !cmd[W_CLR];
      if (cmd[W_CLR] || tout) m_stage = 0;
      else if (m_w && tick)   m_stage = m_stage + 1;
      if (cmd[W_CLR] || cmd[I_OFF]) m_flag = 0;
      else if (tout)                m_flag = 1;
      if (cmd[T_CLR])  m_cnt = 0;
      else if (run)    m_cnt = (m_cnt + 1) % MOD;
      if (cmd[T_OFF]) m_t = 0; else if (cmd[T_ON]) m_t = 1;
      if (cmd[W_OFF]) m_w = 0; else if (cmd[W_ON]) m_w = 1;
      if (cmd[I_OFF]) m_i = 0; else if (cmd[I_ON]) m_i = 1;
      if (cmd[R_LD])  m_rate = int'(rate);
    end
  end

  // per-clock comparison, sampled 2 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && !done) begin
        checks++;
        if (irq_level !== model_level() || irq_drive !== !model_level()) begin
          errors++;
          $display("FAIL %s (R9 model compare): level=%0b drive=%0b expected level=%0b",
                   phase, irq_level, irq_drive, model_level());
        end
      end
    end
  end

  task automatic check_level(input string tag, input bit exp);
    checks++;
    if (irq_level !== exp || irq_drive !== !exp) begin
      errors++;
      $display("FAIL %s: level=%0b drive=%0b expected level=%0b", tag, irq_level, irq_drive, exp);
    end
  endtask

  task automatic pulse(input logic [8:0] c, input logic [2:0] r);
    @(negedge clk);
    cmd  = c;
    rate = r;
    @(negedge clk);
    cmd  = '0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  function automatic logic [8:0] bits(input int a, input int b = -1, input int c = -1,
                                      input int d = -1, input int e = -1);
    logic [8:0] v = '0;
    v[a] = 1'b1;
    if (b >= 0) v[b] = 1'b1;
    if (c >= 0) v[c] = 1'b1;
    if (d >= 0) v[d] = 1'b1;
    if (e >= 0) v[e] = 1'b1;
    return v;
  endfunction

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // watchdog on the bench itself
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, level=%0b expected completion", irq_level);
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check_level("R1 during reset", 1'b1);
    rst_n = 1'b1;
    edges(3);
    check_level("R1 after reset", 1'b1);

    // R9: interrupt on, nothing else: line stays released
    phase = "R9";
    pulse(bits(I_ON), 3'd0);
    edges(5);
    check_level("R9 no source", 1'b1);

    // R3: wave at code 7, period 4 clocks
    phase = "R3";
    pulse(bits(T_ON, T_CLR, R_LD), 3'd7);
    check_level("R3 low half start", 1'b0);
    edges(2);
    check_level("R3 high half", 1'b1);
    edges(2);
    check_level("R3 next period low", 1'b0);
    edges(40);

    // R10: rate changes mid-period, counter not restarted
    phase = "R10";
    pulse(bits(R_LD), 3'd5);
    edges(100);
    pulse(bits(R_LD), 3'd2);
    edges(300);
    pulse(bits(R_LD), 3'd6);
    edges(30);

    // R2: both off, counter holds; line depends on nothing
    phase = "R2";
    pulse(bits(T_OFF), 3'd0);
    edges(50);
    pulse(bits(T_ON), 3'd0);
    edges(30);

    // R4: watchdog alone, code 7: flag on the 16th edge after a joint clear
    phase = "R4";
    pulse(bits(T_OFF, W_ON, T_CLR, W_CLR, R_LD), 3'd7);
    edges(15);
    check_level("R4 before fourth tick", 1'b1);
    edges(1);
    check_level("R4 fourth tick sets flag", 1'b0);

    // R5/R6: counter clear does not touch the flag
    phase = "R5";
    edges(10);
    pulse(bits(T_CLR), 3'd0);
    check_level("R6 counter clear leaves flag", 1'b0);
    edges(20);
    check_level("R5 flag still holding", 1'b0);
    pulse(bits(W_CLR), 3'd0);
    check_level("R5 watchdog clear releases", 1'b1);

    // R5/R9: timeout again, then interrupt off releases and drops the flag
    phase = "R9";
    edges(20);
    check_level("R4 second timeout", 1'b0);
    pulse(bits(I_OFF), 3'd0);
    check_level("R9 interrupt off releases", 1'b1);
    pulse(bits(I_ON, W_OFF), 3'd0);
    check_level("R5 flag dropped by interrupt off", 1'b1);

    // R8: on and off together -> off
    phase = "R8";
    pulse(bits(T_ON, T_OFF), 3'd0);
    edges(12);
    check_level("R8 timer stays off", 1'b1);

    // R7: watchdog toggles while the time base runs
    phase = "R7";
    pulse(bits(T_ON, T_CLR, R_LD), 3'd4);
    edges(20);
    pulse(bits(W_ON), 3'd0);
    edges(60);
    pulse(bits(W_OFF, W_CLR), 3'd0);
    edges(40);
    pulse(bits(I_OFF), 3'd0);
    edges(10);
    check_level("R7 interrupt off alone releases", 1'b1);
    pulse(bits(I_ON), 3'd0);
    edges(40);

    // R4 at code 1: 4*256 clocks with the time base wave also present
    phase = "R4";
    pulse(bits(T_CLR, W_CLR, W_ON, R_LD), 3'd1);
    edges(1023);
    check_level("R4 code 1 before timeout (wave high half)", 1'b1);
    edges(1);
    check_level("R4 code 1 timeout", 1'b0);
    edges(20);

    finish_run();
  end

endmodule